// File: doc/BRIEF.md
# Switch Transition Delay Meter with On-Time Correction

A power stage switch does not follow its gate command at once. The gate driver and the device add a delay before the real turn-on and before the real turn-off. A current estimator that integrates inductor volt-seconds over the commanded on-time picks up an error from each of these delays. This block measures both delays in every switching period and corrects the on-time that the estimator must use. It compares the internal on/off command with a comparator output that shows the level of the switch drain-source voltage. That output is high while the switch blocks and low while it conducts.

A turn-on measurement starts when the command rises and stops when the sensed voltage goes low. A turn-off measurement starts when the command falls and stops when the sensed voltage goes high. The sensed input is asynchronous, so it passes through a synchronizer, and the block removes the fixed latency of that synchronizer from both counts. At the clock edge that samples the next rising command, the block presents the results for the period that has just ended:
- the two delays;
- their signed difference, which is the on-time error;
- the commanded on-time corrected by that difference.

A one-cycle strobe marks each new result. The result stream has no back-pressure: the consumer must take the values while the strobe is high. The values stay on the outputs until the next strobe, so a consumer can also read them later. A programmable limit bounds each measurement and raises a fault flag when the limit is reached.

Top module: `sw_delay_meter`

## Requirements
- R1: While rst_n is low, meas_valid_o, dly_rise_o, dly_fall_o, ton_err_o, ton_corr_o, fault_rise_o and fault_fall_o are all zero.
- R2: The turn-on delay is the number of clock edges from the edge that first samples cmd_on_i high to the edge that first samples vds_hi_i low. The two-stage synchronizer latency is already removed from this count.
- R3: The turn-off delay is the number of clock edges from the edge that first samples cmd_on_i low to the edge that first samples vds_hi_i high. The two-stage synchronizer latency is already removed from this count.
- R4: ton_err_o equals the turn-off delay minus the turn-on delay, as a (CNT_W+1)-bit two's-complement value.
- R5: ton_corr_o equals the number of clock edges that sampled cmd_on_i high in the period plus ton_err_o, clamped to the range 0 to 2^ON_W-1.
- R6: meas_valid_o is high for exactly one cycle, just after the clock edge that samples a rising cmd_on_i. All result outputs update at that same edge. The first period after reset produces no report.
- R7: A delay equal to limit_i is reported exactly, with its fault flag low. A delay greater than limit_i is reported as limit_i, with its fault flag (fault_rise_o or fault_fall_o) high.
- R8: If the sensed level already shows the new switch state when the command edge is sampled, the delay is reported as 0.
- R9: A measurement that has not completed when the next rising command is sampled is reported as limit_i, with its fault flag high.
- R10: Between strobes, all result outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_on_i | input | 1 | Switch command, high means on (synchronous) |
| vds_hi_i | input | 1 | Comparator output of drain-source level, high while switch blocks (asynchronous) |
| limit_i | input | CNT_W | Measurement limit in clocks; hold static outside reset |
| meas_valid_o | output | 1 | One-cycle strobe for a new result |
| dly_rise_o | output | CNT_W | Turn-on delay in clocks |
| dly_fall_o | output | CNT_W | Turn-off delay in clocks |
| ton_err_o | output | CNT_W+1 | Turn-off minus turn-on delay, two's complement |
| ton_corr_o | output | ON_W | Corrected on-time in clocks |
| fault_rise_o | output | 1 | Turn-on measurement hit the limit |
| fault_fall_o | output | 1 | Turn-off measurement hit the limit |

## Verification
Concurrent assertions check on every cycle that the strobe lasts one cycle and follows a sampled command rise. They also check that each running counter stays below its limit, that a flagged result equals the limit, and that the results hold between strobes. The bench has to show the exact delay values, and it does so with a behavioural model that tracks sampled edges:
- the removal of the synchronizer latency;
- the clamp to zero when the level is already reached;
- the limit cases;
- a measurement cut off by the next period;
- both clamps of the corrected on-time.

// File: rtl/dlym_pkg.sv
package dlym_pkg;

  // Clamp an integer into the closed range [0, hi].
  function automatic int clamp_span(int v, int hi);
    if (v < 0) return 0;
    if (v > hi) return hi;
    return v;
  endfunction

  // Remove a fixed latency from a raw count, floored at zero.
  function automatic int strip_latency(int raw, int lat);
    if (raw > lat) return raw - lat;
    return 0;
  endfunction

endpackage

// File: rtl/dlym_sync.sv
module dlym_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    if (gi == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[gi] <= RST_LVL;
        else        chain[gi] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[gi] <= RST_LVL;
        else        chain[gi] <= chain[gi-1];
      end
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/dlym_edge_timer.sv
module dlym_edge_timer
  import dlym_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int LAT    = 2,
  parameter bit TARGET = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             lvl_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] val_o,
  output logic             flt_o
);
  localparam int RAW_W = CNT_W + $clog2(LAT + 2) + 1;

  logic [RAW_W-1:0] cnt;
  logic [RAW_W-1:0] cnt_nxt;
  logic [RAW_W-1:0] lim_raw;
  logic [RAW_W-1:0] stripped;
  logic             run;

  always_comb begin
    cnt_nxt  = cnt + RAW_W'(1);
    lim_raw  = RAW_W'(limit_i) + RAW_W'(LAT);
    stripped = RAW_W'(strip_latency(int'(cnt_nxt), LAT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      cnt   <= '0;
      val_o <= '0;
      flt_o <= 1'b0;
    end else if (start_i) begin
      run   <= 1'b1;
      cnt   <= '0;
      val_o <= '0;
      flt_o <= 1'b0;
    end else if (run) begin
      if (lvl_i == TARGET) begin
        run   <= 1'b0;
        val_o <= stripped[CNT_W-1:0];
      end else if (cnt_nxt >= lim_raw) begin
        run   <= 1'b0;
        val_o <= limit_i;
        flt_o <= 1'b1;
      end else begin
        cnt <= cnt_nxt;
      end
    end
  end

  assign busy_o = run;

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < lim_raw)); // R7

  AST_FAULT_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_o && !run) |-> (val_o == limit_i)); // R7
endmodule

// File: rtl/dlym_report.sv
module dlym_report
  import dlym_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int ON_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             on_busy_i,
  input  logic [CNT_W-1:0] on_val_i,
  input  logic             on_flt_i,
  input  logic             off_busy_i,
  input  logic [CNT_W-1:0] off_val_i,
  input  logic             off_flt_i,
  output logic             rise_o,
  output logic             fall_o,
  output logic             valid_o,
  output logic [CNT_W-1:0] dly_on_o,
  output logic [CNT_W-1:0] dly_off_o,
  output logic [CNT_W:0]   diff_o,
  output logic [ON_W-1:0]  ton_o,
  output logic             flt_on_o,
  output logic             flt_off_o
);
  localparam int LEN_MAX = (1 << ON_W) - 1;

  logic             cmd_q;
  logic             have_prev;
  logic [ON_W-1:0]  len_cnt;
  logic [ON_W-1:0]  len_cap;
  logic [CNT_W-1:0] eff_on;
  logic [CNT_W-1:0] eff_off;
  logic             eff_on_flt;
  logic             eff_off_flt;
  logic [CNT_W:0]   diff_c;
  logic [ON_W-1:0]  ton_c;
  int               ton_sum;

  assign rise_o = cmd_i & ~cmd_q;
  assign fall_o = ~cmd_i & cmd_q;

  // An unfinished measurement is reported as a limit hit.
  always_comb begin
    eff_on      = on_busy_i  ? limit_i : on_val_i;
    eff_off     = off_busy_i ? limit_i : off_val_i;
    eff_on_flt  = on_busy_i  | on_flt_i;
    eff_off_flt = off_busy_i | off_flt_i;
    diff_c      = {1'b0, eff_off} - {1'b0, eff_on};
    ton_sum     = clamp_span(int'(len_cap) + int'(eff_off) - int'(eff_on), LEN_MAX);
    ton_c       = ton_sum[ON_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= 1'b0;
      have_prev <= 1'b0;
      len_cnt   <= '0;
      len_cap   <= '0;
      valid_o   <= 1'b0;
      dly_on_o  <= '0;
      dly_off_o <= '0;
      diff_o    <= '0;
      ton_o     <= '0;
      flt_on_o  <= 1'b0;
      flt_off_o <= 1'b0;
    end else begin
      cmd_q   <= cmd_i;
      valid_o <= 1'b0;
      if (rise_o) begin
        len_cnt   <= ON_W'(1);
        have_prev <= 1'b1;
        if (have_prev) begin
          valid_o   <= 1'b1;
          dly_on_o  <= eff_on;
          dly_off_o <= eff_off;
          diff_o    <= diff_c;
          ton_o     <= ton_c;
          flt_on_o  <= eff_on_flt;
          flt_off_o <= eff_off_flt;
        end
      end else if (cmd_i && (len_cnt != ON_W'(LEN_MAX))) begin
        len_cnt <= len_cnt + ON_W'(1);
      end
      if (fall_o) len_cap <= len_cnt;
    end
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R6

  AST_STROBE_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ($past(cmd_i) && !$past(cmd_i, 2))); // R6

  AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(dly_on_o) && $stable(dly_off_o) && $stable(ton_o))); // R10

  AST_FLAGGED_IS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && flt_on_o) |-> (dly_on_o == limit_i)); // R7
endmodule

// File: rtl/sw_delay_meter.sv
module sw_delay_meter #(
  parameter int CNT_W       = 8,
  parameter int ON_W        = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_on_i,
  input  logic             vds_hi_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             meas_valid_o,
  output logic [CNT_W-1:0] dly_rise_o,
  output logic [CNT_W-1:0] dly_fall_o,
  output logic [CNT_W:0]   ton_err_o,
  output logic [ON_W-1:0]  ton_corr_o,
  output logic             fault_rise_o,
  output logic             fault_fall_o
);
  localparam int NUM_EDGES = 2;

  logic                 vds_s;
  logic                 cmd_rise;
  logic                 cmd_fall;
  logic [NUM_EDGES-1:0] t_start;
  logic [NUM_EDGES-1:0] t_busy;
  logic [NUM_EDGES-1:0] t_flt;
  logic [CNT_W-1:0]     t_val [NUM_EDGES];

  dlym_sync #(.STAGES(SYNC_STAGES), .RST_LVL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (vds_hi_i),
    .q_o   (vds_s)
  );

  assign t_start = {cmd_fall, cmd_rise};

  // Index 0 times turn-on (waits for low), index 1 turn-off (waits for high).
  for (genvar gi = 0; gi < NUM_EDGES; gi++) begin : g_timer
    dlym_edge_timer #(
      .CNT_W  (CNT_W),
      .LAT    (SYNC_STAGES),
      .TARGET ((gi == 0) ? 1'b0 : 1'b1)
    ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (t_start[gi]),
      .lvl_i   (vds_s),
      .limit_i (limit_i),
      .busy_o  (t_busy[gi]),
      .val_o   (t_val[gi]),
      .flt_o   (t_flt[gi])
    );
  end

  dlym_report #(.CNT_W(CNT_W), .ON_W(ON_W)) u_report (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_i      (cmd_on_i),
    .limit_i    (limit_i),
    .on_busy_i  (t_busy[0]),
    .on_val_i   (t_val[0]),
    .on_flt_i   (t_flt[0]),
    .off_busy_i (t_busy[1]),
    .off_val_i  (t_val[1]),
    .off_flt_i  (t_flt[1]),
    .rise_o     (cmd_rise),
    .fall_o     (cmd_fall),
    .valid_o    (meas_valid_o),
    .dly_on_o   (dly_rise_o),
    .dly_off_o  (dly_fall_o),
    .diff_o     (ton_err_o),
    .ton_o      (ton_corr_o),
    .flt_on_o   (fault_rise_o),
    .flt_off_o  (fault_fall_o)
  );
endmodule

// File: tb/sw_delay_meter_test.sv
`timescale 1ns/1ps
module sw_delay_meter_test;
  localparam int CNT_W = 8;
  localparam int ON_W  = 8;
  localparam int LIM   = 20;
  localparam int TMAX  = (1 << ON_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd = 1'b0;
  logic vds = 1'b1;
  logic [CNT_W-1:0] limit = CNT_W'(LIM);
  logic meas_valid, f_rise, f_fall;
  logic [CNT_W-1:0] d_rise, d_fall;
  logic [CNT_W:0]   t_err;
  logic [ON_W-1:0]  t_corr;

  int checks = 0;
  int errs = 0;

  // model state
  int e, pc, pv, v_since, have_prev, vcur;
  int rise_e, fall_e, on_act, on_found, on_d, on_stop, off_act, off_found, off_d, off_stop;
  int x_valid, x_on, x_off, x_diff, x_ton, x_fon, x_foff;

  always #2 clk = ~clk;

  sw_delay_meter #(.CNT_W(CNT_W), .ON_W(ON_W), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_on_i(cmd), .vds_hi_i(vds), .limit_i(limit),
    .meas_valid_o(meas_valid), .dly_rise_o(d_rise), .dly_fall_o(d_fall),
    .ton_err_o(t_err), .ton_corr_o(t_corr), .fault_rise_o(f_rise), .fault_fall_o(f_fall)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    e = 0; pc = 0; pv = 1; v_since = -100; have_prev = 0; vcur = 1;
    on_act = 0; off_act = 0; on_found = 0; off_found = 0;
    x_valid = 0; x_on = 0; x_off = 0; x_diff = 0; x_ton = 0; x_fon = 0; x_foff = 0;
  endtask

  // Behavioural prediction of the outputs after the next rising clock edge.
  task automatic model_edge(int c, int v);
    int ok_on, ok_off, ron, roff, len;
    e++;
    if (v != pv) v_since = e;
    x_valid = 0;
    if (on_act && !on_found && v == 0) begin on_found = 1; on_d = e - rise_e; on_stop = e + 2; end
    if (off_act && !off_found && v == 1) begin off_found = 1; off_d = e - fall_e; off_stop = e + 2; end
    if (c == 1 && pc == 0) begin
      if (have_prev) begin
        ok_on  = on_found  && on_d  <= LIM && on_stop  < e;
        ok_off = off_found && off_d <= LIM && off_stop < e;
        ron  = ok_on  ? on_d  : LIM;
        roff = ok_off ? off_d : LIM;
        len  = fall_e - rise_e;
        if (len > TMAX) len = TMAX;
        x_valid = 1; x_on = ron; x_off = roff; x_diff = roff - ron;
        x_ton = len + roff - ron;
        if (x_ton < 0) x_ton = 0;
        if (x_ton > TMAX) x_ton = TMAX;
        x_fon = !ok_on; x_foff = !ok_off;
      end
      have_prev = 1; rise_e = e; on_act = 1; off_act = 0; off_found = 0;
      if (v == 0) begin
        on_found = 1; on_d = 0; on_stop = (v_since + 2 > e + 1) ? v_since + 2 : e + 1;
      end else on_found = 0;
    end
    if (c == 0 && pc == 1) begin
      fall_e = e; off_act = 1;
      if (v == 1) begin
        off_found = 1; off_d = 0; off_stop = (v_since + 2 > e + 1) ? v_since + 2 : e + 1;
      end else off_found = 0;
    end
    pc = c; pv = v;
  endtask

  task automatic compare();
    chk("R6 strobe", int'(meas_valid), x_valid);
    if (x_valid) begin
      chk("R2 turn-on delay", int'(d_rise), x_on);
      chk("R3 turn-off delay", int'(d_fall), x_off);
      chk("R4 on-time error", int'($signed(t_err)), x_diff);
      chk("R5 corrected on-time", int'(t_corr), x_ton);
      chk("R7 turn-on fault", int'(f_rise), x_fon);
      chk("R7 turn-off fault", int'(f_fall), x_foff);
    end else begin
      chk("R10 hold turn-on", int'(d_rise), x_on);
      chk("R10 hold turn-off", int'(d_fall), x_off);
      chk("R10 hold corrected", int'(t_corr), x_ton);
    end
  endtask

  task automatic tick(int c, int v);
    @(negedge clk);
    compare();
    cmd = c[0]; vds = v[0];
    model_edge(c, v);
  endtask

  // on_d / off_d: offset of the sensed transition after the command edge; -1 = none
  task automatic run_period(int on_d, int on_len, int off_d, int off_len);
    int v;
    v = vcur;
    for (int t = 0; t < on_len + off_len; t++) begin
      v = vcur;
      if (off_d >= 0 && t >= on_len + off_d) v = 1;
      else if (on_d >= 0 && t >= on_d) v = 0;
      tick((t < on_len) ? 1 : 0, v);
    end
    vcur = v;
  endtask

  task automatic check_reset_state();
    chk("R1 strobe", int'(meas_valid), 0);
    chk("R1 turn-on delay", int'(d_rise), 0);
    chk("R1 turn-off delay", int'(d_fall), 0);
    chk("R1 error", int'(t_err), 0);
    chk("R1 corrected", int'(t_corr), 0);
    chk("R1 faults", int'(f_rise) + int'(f_fall), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    model_edge(0, 1);
    repeat (5) tick(0, 1);

    run_period(3, 40, 5, 40);     // first period: no report (R6)
    run_period(4, 50, 6, 40);     // R2 R3 R4 R5 nominal
    run_period(7, 30, 2, 60);     // negative error
    run_period(25, 40, 3, 40);    // R7 turn-on beyond limit
    run_period(20, 40, 20, 40);   // R7 exactly at limit, no fault
    run_period(2, 30, -1, 20);    // R9 turn-off never completes
    run_period(5, 40, 4, 40);     // R8 sensed level already low at rise
    run_period(1, 40, 1, 40);
    run_period(-1, 5, 0, 40);     // R8 turn-off instant; R5 clamp at zero
    run_period(0, 40, 0, 40);     // transition sampled at the command edge
    run_period(2, 250, 12, 40);   // R5 clamp at upper bound
    run_period(3, 30, 3, 30);     // flushes previous result

    // mid-run reset: R1 again, then first period unreported
    @(negedge clk);
    rst_n = 1'b0; cmd = 1'b0; vds = 1'b1;
    model_reset();
    @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    model_edge(0, 1);
    repeat (4) tick(0, 1);
    run_period(6, 35, 9, 35);
    run_period(2, 35, 2, 35);
    run_period(4, 35, 4, 35);
    repeat (4) tick(0, 1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule